// File: doc/BRIEF.md
# Signaling NaN Detect and Quiet Unit

This block takes one 64-bit IEEE 754 double-precision operand per strobe. It sorts the operand into one of six classes: zero, subnormal, normal, infinity, quiet NaN or signaling NaN. When the operand is a signaling NaN, the block replaces it with a quiet NaN and raises an invalid-operation flag for that operand. Every other operand passes through untouched, with no flag.

Two NaN encodings are supported, and a mode bit that travels with each operand selects between them.

- **Legacy convention:** a set top fraction bit marks a NaN as signaling. Quieting clears that bit. If clearing it would leave the fraction zero, and so turn the result into an infinity, the next fraction bit down is set instead.
- **Newer convention (mode bit high):** a set top fraction bit marks a NaN as quiet. Quieting sets that bit.

Results appear on registered outputs one clock after the strobe.

Top module: `snan_quiet_unit`

## Requirements
- R1: With valid high, an operand whose exponent field (bits 62:52) is zero gives class code 0 (zero) if its fraction (bits 51:0) is zero, and class code 1 (subnormal) if the fraction is nonzero. Any exponent that is neither all zeros nor all ones gives class code 2 (normal).
- R2: An exponent field of all ones with a zero fraction gives class code 3 (infinity). An exponent field of all ones with a nonzero fraction is a NaN, and gets class code 4 or 5.
- R3: A NaN is signaling, class code 5, when fraction bit 51 XOR the mode bit equals 1. Otherwise it is quiet, class code 4.
- R4: With the mode bit high, a signaling NaN is output with bit 51 set. Every other bit is unchanged.
- R5: With the mode bit low, a signaling NaN is output with bit 51 cleared. If the fraction is then zero, bit 50 is set, so the result is never an infinity. Every other bit is unchanged.
- R6: The invalid flag goes high exactly for a strobed operand that is a signaling NaN.
- R7: An operand that is not a signaling NaN is output bit-for-bit unchanged, including the sign bit 63.
- R8: Class, result and flag appear one clock after the edge that samples valid high, and the output valid goes high for that one cycle. In a cycle after valid was low, the output valid and the flag are low, and the class and result hold their previous values.
- R9: Synchronous active-low reset clears the output valid, the flag, the class and the result to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| op_in | input | 64 | Double-precision operand |
| mode_2008 | input | 1 | NaN convention: 1 means a set bit 51 is quiet, 0 means it is signaling |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| class_out | output | 3 | Class code: 0 zero, 1 subnormal, 2 normal, 3 infinity, 4 quiet NaN, 5 signaling NaN |
| result_out | output | 64 | Quieted or passed-through operand |
| invalid_out | output | 1 | Invalid-operation flag |

## Verification
On every cycle, the assertions check the following:
- the flag is only ever raised together with the output valid;
- the output valid follows the strobe by exactly one cycle;
- a flagged result is always a NaN and never an infinity;
- the quiet-indicator bit of a flagged result matches the convention that was in force;
- the sign bit is never altered.

Some behaviours can only be shown by the bench's scenarios against its reference model:
- the exact class code for each operand kind;
- the bit 50 fallback, when a legacy signaling NaN has an otherwise empty payload;
- unchanged pass-through of quiet NaNs, and of infinities under each convention;
- held outputs during idle cycles.

// File: rtl/snan_quiet_pkg.sv
// Package: shared field widths and the class code encoding for the
// signaling NaN unit. Assumes an IEEE 754 binary64 layout by default.
package snan_quiet_pkg;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_SUBN = 3'd1,
        CLS_NORM = 3'd2,
        CLS_INF  = 3'd3,
        CLS_QNAN = 3'd4,
        CLS_SNAN = 3'd5
    } fp_class_e;
endpackage

// File: rtl/fp_classifier.sv
// Module: fp_classifier
// Purely combinational. Splits an operand into its exponent and fraction
// fields and produces its class code and a signaling flag.
// Assumes the quiet-indicator bit is the top fraction bit.
module fp_classifier
    import snan_quiet_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W,
    localparam int W = 1 + EW + FW
) (
    input  logic [W-1:0] word_i,
    input  logic         mode_2008_i,
    output fp_class_e    class_o,
    output logic         snan_o
);
    logic [EW-1:0] exp_f;
    logic [FW-1:0] frac_f;
    logic          exp_ones, exp_zero, frac_nz, qbit;

    // Field extraction and summary terms.
    always_comb begin
        exp_f    = word_i[W-2 -: EW];
        frac_f   = word_i[FW-1:0];
        exp_ones = &exp_f;
        exp_zero = ~|exp_f;
        frac_nz  = |frac_f;
        qbit     = frac_f[FW-1];
    end

    // Class decode; the top fraction bit and the mode decide signaling.
    always_comb begin
        snan_o = 1'b0;
        if (exp_zero)
            class_o = frac_nz ? CLS_SUBN : CLS_ZERO;
        else if (!exp_ones)
            class_o = CLS_NORM;
        else if (!frac_nz)
            class_o = CLS_INF;
        else if (qbit ^ mode_2008_i) begin
            class_o = CLS_SNAN;
            snan_o  = 1'b1;
        end else
            class_o = CLS_QNAN;
    end
endmodule

// File: rtl/nan_quieter.sv
// Module: nan_quieter
// Purely combinational. Forms the quiet form of an operand, assuming the
// caller already knows that the operand is a signaling NaN. Sign,
// exponent and the remaining payload bits are kept as they are.
module nan_quieter
    import snan_quiet_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W,
    localparam int W = 1 + EW + FW
) (
    input  logic [W-1:0] word_i,
    input  logic         mode_2008_i,
    output logic [W-1:0] quiet_o
);
    logic [FW-1:0] frac_new;

    // Set the quiet bit (newer convention), or clear it and keep the value a NaN (legacy).
    always_comb begin
        frac_new = word_i[FW-1:0];
        if (mode_2008_i) begin
            frac_new[FW-1] = 1'b1;
        end else begin
            frac_new[FW-1] = 1'b0;
            if (frac_new == '0)
                frac_new[FW-2] = 1'b1;
        end
        quiet_o = {word_i[W-1:FW], frac_new};
    end
endmodule

// File: rtl/snan_quiet_unit.sv
// Module: snan_quiet_unit (top)
// Classifies a strobed double and quiets signaling NaNs under a
// per-operand NaN convention. All outputs are registered, with a latency
// of one cycle. Assumes a synchronous active-low reset.
module snan_quiet_unit
    import snan_quiet_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W,
    localparam int W = 1 + EW + FW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] op_in,
    input  logic         mode_2008,
    output logic         out_valid,
    output logic [2:0]   class_out,
    output logic [W-1:0] result_out,
    output logic         invalid_out
);
    fp_class_e    cls_c;
    logic         snan_c;
    logic [W-1:0] quiet_c;

    fp_classifier #(.EW(EW), .FW(FW)) u_cls (
        .word_i      (op_in),
        .mode_2008_i (mode_2008),
        .class_o     (cls_c),
        .snan_o      (snan_c)
    );

    nan_quieter #(.EW(EW), .FW(FW)) u_qt (
        .word_i      (op_in),
        .mode_2008_i (mode_2008),
        .quiet_o     (quiet_c)
    );

    // Output register: capture on a strobe, otherwise hold the data and drop valid and flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            invalid_out <= 1'b0;
            class_out   <= '0;
            result_out  <= '0;
        end else begin
            out_valid   <= in_valid;
            invalid_out <= in_valid & snan_c;
            if (in_valid) begin
                class_out  <= cls_c;
                result_out <= snan_c ? quiet_c : op_in;
            end
        end
    end

    AST_FLAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_out |-> out_valid);                                      // R6
    AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                         // R8
    AST_QUIETED_IS_NAN: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_out |-> ((&result_out[W-2 -: EW]) && (|result_out[FW-1:0]))); // R5
    AST_QBIT_MATCHES_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && snan_c) |=> (result_out[FW-1] == $past(mode_2008))); // R4
    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (result_out[W-1] == $past(op_in[W-1])));            // R7
endmodule

// File: tb/tb_snan_quiet_unit.sv
// Bench: behavioural reference model, compared against the outputs on every cycle.
module tb_snan_quiet_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_in = '0;
    logic        mode_2008 = 1'b0;
    logic        out_valid, invalid_out;
    logic [2:0]  class_out;
    logic [63:0] result_out;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // Expected state of the outputs, carried from one cycle to the next.
    logic        e_valid = 0, e_inv = 0;
    logic [2:0]  e_cls = 0;
    logic [63:0] e_res = 0;

    always #4 clk = ~clk;

    snan_quiet_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_in(op_in),
        .mode_2008(mode_2008), .out_valid(out_valid), .class_out(class_out),
        .result_out(result_out), .invalid_out(invalid_out)
    );

    // Reference model: class code, signaling flag and result for one operand.
    function automatic void model(input logic [63:0] x, input logic m,
                                  output logic [2:0] c, output logic s,
                                  output logic [63:0] r);
        int unsigned e = x[62:52];
        logic [51:0] f = x[51:0];
        s = 0;
        r = x;
        if (e == 0)          c = (f == 0) ? 3'd0 : 3'd1;
        else if (e != 2047)  c = 3'd2;
        else if (f == 0)     c = 3'd3;
        else if (x[51] != m) begin
            c = 3'd5;
            s = 1;
            if (m) f[51] = 1'b1;
            else begin
                f[51] = 1'b0;
                if (f == 0) f[50] = 1'b1;
            end
            r = {x[63:52], f};
        end else             c = 3'd4;
    endfunction

    // Compare every output with the expectation and count a miscompare once.
    task automatic compare(input string tag);
        vectors++;
        if (out_valid !== e_valid || invalid_out !== e_inv ||
            class_out !== e_cls || result_out !== e_res) begin
            errors++;
            $display("FAIL %s: got v=%0b inv=%0b cls=%0d res=%h, expected v=%0b inv=%0b cls=%0d res=%h",
                     tag, out_valid, invalid_out, class_out, result_out,
                     e_valid, e_inv, e_cls, e_res);
        end
    endtask

    // Drive one cycle at a falling edge, then check at the next falling edge.
    task automatic apply(input logic v, input logic [63:0] x, input logic m, input string tag);
        logic [2:0]  c;
        logic        s;
        logic [63:0] r;
        in_valid  = v;
        op_in     = x;
        mode_2008 = m;
        model(x, m, c, s, r);
        e_valid = v;
        e_inv   = v & s;
        if (v) begin
            e_cls = c;
            e_res = r;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        logic [63:0] lcg = 64'h1234_5678_9abc_def1;
        repeat (3) @(negedge clk);
        compare("R9 reset state");
        rst_n = 1'b1;
        apply(1, 64'h0000_0000_0000_0000, 0, "R1 +zero");
        apply(1, 64'h8000_0000_0000_0000, 1, "R1 -zero");
        apply(1, 64'h0000_0000_0000_0001, 0, "R1 subnormal");
        apply(1, 64'h3FF0_0000_0000_0000, 1, "R1 normal");
        apply(1, 64'hFFF0_0000_0000_0000, 0, "R2 -inf legacy");
        apply(1, 64'h7FF0_0000_0000_0000, 1, "R2 +inf 2008");
        apply(1, 64'h7FF0_0000_0000_0001, 0, "R3 legacy quiet NaN");
        apply(1, 64'h7FF8_0000_0000_0000, 1, "R3 2008 quiet NaN");
        apply(1, 64'h7FF0_0000_0000_0001, 1, "R4 2008 sNaN quieted");
        apply(1, 64'hFFF0_0000_0000_00AB, 1, "R4 2008 sNaN neg");
        apply(1, 64'h7FF8_0000_0000_0000, 0, "R5 legacy sNaN empty payload");
        apply(1, 64'hFFF8_0000_0000_0000, 0, "R5 legacy neg sNaN empty payload");
        apply(1, 64'h7FF8_0000_0000_1234, 0, "R5 legacy sNaN with payload");
        apply(1, 64'h7FFC_0000_0000_0000, 0, "R6 legacy sNaN bit50 set");
        apply(0, 64'h7FF8_0000_0000_0000, 0, "R8 idle holds");
        apply(0, 64'h0000_0000_0000_0000, 1, "R8 idle holds again");
        apply(1, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R7 legacy all-ones");
        apply(1, 64'hFFFF_FFFF_FFFF_FFFF, 1, "R7 2008 all-ones passes");
        for (int i = 0; i < 400; i++) begin
            lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
            if (i % 3 != 0) lcg[62:52] = 11'h7FF;
            if (i % 11 == 0) lcg[50:0] = '0;
            apply(lcg[7] | lcg[9], lcg, lcg[3], "R6 R7 random");
        end
        rst_n = 1'b0;
        e_valid = 0; e_inv = 0; e_cls = 0; e_res = 0;
        @(negedge clk);
        compare("R9 reset after traffic");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule